// File: doc/BRIEF.md
# Wrapped Burst Column Address Generator

This block turns one burst request into the column address of every beat of a memory read or write burst. A request gives a starting column, a burst-length code and an order bit. From the clock after the request, the block puts out one column per clock for exactly as many beats as the burst length. Each beat has a valid flag, and the final beat also has a last flag. Read bursts and write bursts use the same length setting.

The start column is split in two parts. The upper part picks an aligned block whose size equals the burst length, and this part is held for the whole burst. The low part picks the first beat inside that block. The low part then advances in one of two ways:

- **Sequential order:** it counts up and wraps inside the block. It never carries into the upper part.
- **Interleaved order:** it is the start value XOR the beat index.

The control path is a two-state machine with the states IDLE and RUN. It has four named transitions:

- **GO** (IDLE to RUN): taken on a start strobe.
- **STEP** (RUN to RUN): taken on a beat that is not the last one.
- **RESTART** (RUN to RUN): taken on a start strobe during a burst. It aborts the current burst.
- **DONE** (RUN to IDLE): taken on the last beat when no start strobe is present.

Top module: `burst_col_gen`

## Requirements
- R1: After a start strobe sampled at clock edge n, `col_vld` is high in the cycles after edges n+1 through n+L, where L is the burst length. It is low in the following cycle unless a new start strobe arrived.
- R2: `col_last` is high only on the final beat of a burst, and only together with `col_vld`.
- R3: Column bits at and above position log2(L) equal the start column on every beat. Bits at and above position 4 never change within a burst.
- R4: With `ilv_order` = 0 (sequential), the low log2(L) bits of beat i are (start low bits + i) modulo L.
- R5: With `ilv_order` = 1 (interleaved), the low log2(L) bits of beat i are the start low bits XOR i.
- R6: The `len_code` value sets the burst length: 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b100 gives 16.
- R7: Any other `len_code` value gives a burst of length 2. In that case `len_err` is high for exactly one cycle, together with the first beat.
- R8: A start strobe during a burst aborts that burst. The first beat of the new burst appears in the next cycle.
- R9: After reset, `col_vld`, `col_last` and `len_err` are low.
- R10: `len_code`, `ilv_order` and `start_col` are sampled only when the start strobe is present. Changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe for a burst |
| start_col | input | COL_W | Starting column address |
| len_code | input | 3 | Burst-length code |
| ilv_order | input | 1 | 0 = sequential, 1 = interleaved |
| col_out | output | COL_W | Column address of the current beat |
| col_vld | output | 1 | Current beat is valid |
| col_last | output | 1 | Current beat is the last of the burst |
| len_err | output | 1 | Illegal length code seen at start |

## Verification
Two events can meet in one cycle: the last beat of a burst, and a start strobe that begins the next burst. At that point the DONE transition and the RESTART transition compete. The bench issues a start on the exact cycle of a last beat, and also in the middle of a burst. It judges that there is no idle gap, and that the first beat of the new burst follows at once with the new address, length and error flag. The scoreboard drops the expected beats of an aborted burst when the new strobe is driven. Any stale beat from the old burst would therefore show up as a mismatch.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int unsigned LOW_W = 4;

    localparam logic [2:0] LC_BL2  = 3'b001;
    localparam logic [2:0] LC_BL4  = 3'b010;
    localparam logic [2:0] LC_BL8  = 3'b011;
    localparam logic [2:0] LC_BL16 = 3'b100;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bcg_state_e;

    typedef struct packed {
        logic [LOW_W-1:0] mask;
        logic [LOW_W-1:0] last_idx;
        logic             illegal;
    } bcg_len_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
(
    input  logic [2:0] code,
    output bcg_len_t   len
);
    always_comb begin
        len.illegal = 1'b0;
        unique case (code)
            LC_BL2:  len.mask = 4'b0001;
            LC_BL4:  len.mask = 4'b0011;
            LC_BL8:  len.mask = 4'b0111;
            LC_BL16: len.mask = 4'b1111;
            default: begin
                len.mask    = 4'b0001;
                len.illegal = 1'b1;
            end
        endcase
        len.last_idx = len.mask;
    end
endmodule

// File: rtl/bcg_beat_order.sv
module bcg_beat_order
    import bcg_pkg::*;
#(
    parameter int unsigned W = LOW_W
)(
    input  logic [W-1:0] start_low,
    input  logic [W-1:0] beat,
    input  logic [W-1:0] mask,
    input  logic         ilv,
    output logic [W-1:0] low
);
    logic [W-1:0] seq_low;
    logic [W-1:0] ilv_low;

    assign seq_low = start_low + beat;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            assign ilv_low[b] = start_low[b] ^ beat[b];
            assign low[b]     = mask[b] & (ilv ? ilv_low[b] : seq_low[b]);
        end
    endgenerate
endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LOW_W-1:0] last_idx_in,
    output logic             vld,
    output logic             last,
    output logic [LOW_W-1:0] beat
);
    bcg_state_e       state_q, state_d;
    logic [LOW_W-1:0] cnt_q;
    logic [LOW_W-1:0] lim_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)              state_d = ST_RUN;
                else if (cnt_q == lim_q) state_d = ST_IDLE;
                else                    state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q <= '0;
                lim_q <= last_idx_in;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        vld  = (state_q == ST_RUN);
        last = vld && (cnt_q == lim_q);
        beat = cnt_q;
    end

    AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !vld); // R1
    AST_START_NEXT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (vld && beat == '0)); // R8
    AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> vld); // R2
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W = 10
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv_order,
    output logic [COL_W-1:0] col_out,
    output logic             col_vld,
    output logic             col_last,
    output logic             len_err
);
    localparam int unsigned HI_W = COL_W - LOW_W;

    bcg_len_t         len_dec;
    logic [COL_W-1:0] base_q;
    logic [LOW_W-1:0] mask_q;
    logic             ilv_q;
    logic             err_q;
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] low;

    initial begin
        if (COL_W < 5) $error("COL_W must be at least 5");
    end

    bcg_len_decode u_dec (
        .code (len_code),
        .len  (len_dec)
    );

    bcg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .last_idx_in (len_dec.last_idx),
        .vld         (col_vld),
        .last        (col_last),
        .beat        (beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= start && len_dec.illegal;
            if (start) begin
                base_q <= start_col;
                mask_q <= len_dec.mask;
                ilv_q  <= ilv_order;
            end
        end
    end

    bcg_beat_order #(.W(LOW_W)) u_ord (
        .start_low (base_q[LOW_W-1:0]),
        .beat      (beat),
        .mask      (mask_q),
        .ilv       (ilv_q),
        .low       (low)
    );

    assign col_out = {base_q[COL_W-1:LOW_W], (base_q[LOW_W-1:0] & ~mask_q) | low};
    assign len_err = err_q;

    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && $past(col_vld) && !$past(start))
        |-> (col_out[COL_W-1:LOW_W] == $past(col_out[COL_W-1:LOW_W]))); // R3
    AST_ERR_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> ($past(start) && col_vld)); // R7
    AST_ERR_SHORT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !start) |=> (col_vld && col_last)); // R7
    AST_NO_LAST_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_vld); // R2
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    localparam int COL_W = 10;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        logic             err;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = 3'b001;
    logic             ilv_order = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_vld, col_last, len_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    burst_col_gen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv_order(ilv_order), .col_out(col_out),
        .col_vld(col_vld), .col_last(col_last), .len_err(len_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: issue one start strobe (at negedge) and queue its expected beats
    task automatic drive_start(input logic [COL_W-1:0] c, input logic [2:0] code,
                               input logic ilv, input string tag);
        int len;
        bit bad;
        logic [COL_W-1:0] m;
        @(negedge clk);
        case (code)
            3'b001: begin len = 2;  bad = 0; end   // R6
            3'b010: begin len = 4;  bad = 0; end
            3'b011: begin len = 8;  bad = 0; end
            3'b100: begin len = 16; bad = 0; end
            default: begin len = 2; bad = 1; end   // R7
        endcase
        m = COL_W'(len - 1);
        sb.delete(); // R8: remaining beats of an aborted burst are dropped
        for (int i = 0; i < len; i++) begin
            exp_t e;
            logic [COL_W-1:0] lo;
            lo = ilv ? ((c ^ COL_W'(i)) & m) : ((c + COL_W'(i)) & m);
            e.col  = (c & ~m) | lo;
            e.last = (i == len - 1);
            e.err  = bad && (i == 0);
            e.tag  = tag;
            sb.push_back(e);
        end
        start = 1'b1; start_col = c; len_code = code; ilv_order = ilv;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (col_vld) begin
                    if (sb.size() == 0) begin
                        check(0, "R1 unexpected beat", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(col_out == e.col, e.tag, int'(col_out), int'(e.col));
                        check(col_last == e.last, "R2 last flag", int'(col_last), int'(e.last));
                        check(len_err == e.err, "R7 error flag", int'(len_err), int'(e.err));
                    end
                end else begin
                    if (sb.size() != 0) check(0, "R1 missing beat", 0, 1);
                    if (col_last || len_err) check(0, "R2 flag while idle", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(col_vld == 0 && col_last == 0 && len_err == 0, "R9 reset state",
              int'({col_vld, col_last, len_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(col_vld == 0, "R9 idle after reset", int'(col_vld), 0);

        // R4 sequential, every length, various offsets
        drive_start(10'h2A5, 3'b001, 0, "R4 seq bl2");  drain();
        drive_start(10'h1B3, 3'b010, 0, "R4 seq bl4");  drain();
        drive_start(10'h0D6, 3'b011, 0, "R4 seq bl8");  drain();
        drive_start(10'h3FB, 3'b100, 0, "R4 seq bl16 R3"); drain();
        // R5 interleaved
        drive_start(10'h155, 3'b001, 1, "R5 ilv bl2");  drain();
        drive_start(10'h0F2, 3'b010, 1, "R5 ilv bl4");  drain();
        drive_start(10'h24D, 3'b011, 1, "R5 ilv bl8");  drain();
        drive_start(10'h3F9, 3'b100, 1, "R5 ilv bl16 R3"); drain();
        // R7 illegal codes
        drive_start(10'h1C7, 3'b000, 0, "R7 illegal 000"); drain();
        drive_start(10'h0AA, 3'b111, 1, "R7 illegal 111"); drain();
        // R8 abort mid-burst
        drive_start(10'h10C, 3'b100, 0, "R8 aborted");
        repeat (4) @(negedge clk);
        drive_start(10'h207, 3'b011, 1, "R8 restart"); drain();
        // R8 start exactly on the last beat: no gap
        drive_start(10'h031, 3'b010, 0, "R8 first");
        repeat (2) @(negedge clk); // beats 0..2 seen, last beat now pending
        drive_start(10'h3C6, 3'b101, 0, "R8 back-to-back R7"); drain();
        // R10 inputs changed during a burst have no effect
        drive_start(10'h16E, 3'b011, 0, "R10 held inputs");
        len_code = 3'b100; ilv_order = 1'b1; start_col = 10'h000;
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule